// File: doc/BRIEF.md
# Preset Compare Output Controller

This block stores twelve signed 24-bit preset values and compares each against a live position accumulator on every clock. Four of the presets drive real-time outputs. The other eight are limit-switch style flags, and their results are only reported. Each comparison has its own sense bit, which chooses between "at or above the preset" and "below the preset". The result vector is registered once per clock.

Each real-time output has its own enable bit and its own latch bit. Both vectors are loaded together by one command strobe. An enabled output follows its comparison. A latched output that is already on stays on until it is unlatched and its enable and comparison call for off.

A home-search signal clears all enables and latches. While a host-reset signal is high, an optional masking mode can hold the outputs off without disturbing the stored output state.

Top module: `preset_cmp_ctrl`

## Requirements
- R1: When `pst_we_i` is high, the preset chosen by `pst_sel_i` is loaded from `pst_data_i` at the clock edge. Codes 0 to 3 select the output presets and codes 4 to 11 select the internal presets. Codes 12 to 15 change nothing.
- R2: Bit k of `cmp_o` (0 to 3 for outputs, 4 to 11 for internal presets) is valid one clock after `acc_i` is applied. With `sense_i[k]`=0 the bit is 1 when signed `acc_i` >= preset k. With `sense_i[k]`=1 the bit is 1 when signed `acc_i` < preset k.
- R3: An output whose enable bit is 1 turns on one clock after its bit in `cmp_o` becomes 1.
- R4: An output turns off one clock after its comparison bit goes to 0, unless its latch bit is 1 while it is on. A latched output that is on stays on whatever happens to enable or comparison. A latch never turns on an output that is off.
- R5: A pulse on `dcmd_we_i` loads `dcmd_en_i` and `dcmd_lat_i` as the enable and latch vectors (bit i for output i).
- R6: While `home_act_i` is high, all enable and latch bits are cleared and `dcmd_we_i` is ignored. After it falls, the outputs stay disabled until a new command sets the enable bits.
- R7: With `force_off_sel_i`=1 and `host_rst_i`=1, `out_o` is 0 in the same cycle. On release, the outputs show the state that enable, latch and comparison hold. With `force_off_sel_i`=0, `host_rst_i` has no effect.
- R8: After reset all presets are zero, all enable and latch bits are 0, and `out_o` is 0. With `acc_i`=0 and all sense bits 0, `cmp_o` becomes 12'hFFF one clock after reset release.
- R9: The internal presets (bits 4 to 11) never affect `out_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_i | input | 24 | Live accumulator, two's complement |
| pst_we_i | input | 1 | Preset write strobe |
| pst_sel_i | input | 4 | Preset index, 0 to 11 |
| pst_data_i | input | 24 | Preset write value |
| sense_i | input | 12 | Per-preset comparison sense |
| dcmd_we_i | input | 1 | Enable/latch command strobe |
| dcmd_en_i | input | 4 | Output enable bits |
| dcmd_lat_i | input | 4 | Output latch bits |
| home_act_i | input | 1 | Home search in progress |
| host_rst_i | input | 1 | Host controller held in reset |
| force_off_sel_i | input | 1 | Mask outputs while host is in reset |
| out_o | output | 4 | Real-time output states |
| cmp_o | output | 12 | Registered comparison results |

## Verification
The checker watches four things on every cycle:
- the masking of `out_o` during host reset;
- the hold of a latched, lit output;
- the turn-off of an unlatched output whose comparison failed;
- that a disabled, dark output never turns on, and that home search clears enables and latches.

Only the bench scenarios can show the rest:
- the signed comparison in both senses across negative and positive values;
- that out-of-range preset indices are ignored;
- that internal presets cannot reach the outputs;
- the ordering of latch, enable and compare across sequences of commands.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
    localparam int PCMP_ACC_W = 24;
    localparam int PCMP_N_OUT = 4;
    localparam int PCMP_N_INT = 8;
    localparam int PCMP_N_PRE = PCMP_N_OUT + PCMP_N_INT;

    typedef enum logic {
        SENSE_AT_OR_ABOVE = 1'b0,
        SENSE_BELOW       = 1'b1
    } sense_e;
endpackage

// File: rtl/pcmp_preset_bank.sv
module pcmp_preset_bank #(
    parameter int ACC_W = pcmp_pkg::PCMP_ACC_W,
    parameter int N_PRE = pcmp_pkg::PCMP_N_PRE,
    parameter int SEL_W = $clog2(N_PRE)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [SEL_W-1:0]            sel_i,
    input  logic [ACC_W-1:0]            data_i,
    output logic [N_PRE-1:0][ACC_W-1:0] pre_o
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_PRE - 1);

    typedef struct packed {
        logic [N_PRE-1:0][ACC_W-1:0] pre;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < N_PRE; k++) begin
            if (we_i && (sel_i <= LAST_SEL) && (sel_i == SEL_W'(k)))
                st_d.pre[k] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_o = st_q.pre;
endmodule

// File: rtl/pcmp_cmp_array.sv
module pcmp_cmp_array #(
    parameter int ACC_W = pcmp_pkg::PCMP_ACC_W,
    parameter int N_PRE = pcmp_pkg::PCMP_N_PRE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ACC_W-1:0]            acc_i,
    input  logic [N_PRE-1:0][ACC_W-1:0] pre_i,
    input  logic [N_PRE-1:0]            sense_i,
    output logic [N_PRE-1:0]            hit_o
);
    typedef struct packed {
        logic [N_PRE-1:0] hit;
    } cmp_t;

    cmp_t             st_d, st_q;
    logic [N_PRE-1:0] raw_hit;

    for (genvar k = 0; k < N_PRE; k++) begin : g_cmp
        logic below;
        assign below      = $signed(acc_i) < $signed(pre_i[k]);
        assign raw_hit[k] = (sense_i[k] == pcmp_pkg::SENSE_BELOW) ? below : !below;
    end

    always_comb begin
        st_d     = st_q;
        st_d.hit = raw_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = st_q.hit;
endmodule

// File: rtl/pcmp_out_ctrl.sv
module pcmp_out_ctrl #(
    parameter int N_OUT = pcmp_pkg::PCMP_N_OUT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OUT-1:0] hit_i,
    input  logic             cmd_we_i,
    input  logic [N_OUT-1:0] cmd_en_i,
    input  logic [N_OUT-1:0] cmd_lat_i,
    input  logic             home_act_i,
    input  logic             host_rst_i,
    input  logic             force_off_sel_i,
    output logic [N_OUT-1:0] en_o,
    output logic [N_OUT-1:0] lat_o,
    output logic [N_OUT-1:0] live_o,
    output logic [N_OUT-1:0] out_o
);
    typedef struct packed {
        logic [N_OUT-1:0] en;
        logic [N_OUT-1:0] lat;
        logic [N_OUT-1:0] live;
    } octl_t;

    octl_t st_d, st_q;
    logic  mask_all;

    always_comb begin
        st_d = st_q;
        if (home_act_i) begin
            st_d.en  = '0;
            st_d.lat = '0;
        end else if (cmd_we_i) begin
            st_d.en  = cmd_en_i;
            st_d.lat = cmd_lat_i;
        end
        st_d.live = (hit_i & st_q.en) | (st_q.live & st_q.lat);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_all = force_off_sel_i && host_rst_i;
    assign en_o     = st_q.en;
    assign lat_o    = st_q.lat;
    assign live_o   = st_q.live;
    assign out_o    = st_q.live & ~{N_OUT{mask_all}};
endmodule

// File: rtl/preset_cmp_ctrl.sv
module preset_cmp_ctrl #(
    parameter int ACC_W = pcmp_pkg::PCMP_ACC_W,
    parameter int N_OUT = pcmp_pkg::PCMP_N_OUT,
    parameter int N_INT = pcmp_pkg::PCMP_N_INT,
    parameter int N_PRE = N_OUT + N_INT,
    parameter int SEL_W = $clog2(N_PRE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             pst_we_i,
    input  logic [SEL_W-1:0] pst_sel_i,
    input  logic [ACC_W-1:0] pst_data_i,
    input  logic [N_PRE-1:0] sense_i,
    input  logic             dcmd_we_i,
    input  logic [N_OUT-1:0] dcmd_en_i,
    input  logic [N_OUT-1:0] dcmd_lat_i,
    input  logic             home_act_i,
    input  logic             host_rst_i,
    input  logic             force_off_sel_i,
    output logic [N_OUT-1:0] out_o,
    output logic [N_PRE-1:0] cmp_o
);
    logic [N_PRE-1:0][ACC_W-1:0] pre_w;
    logic [N_PRE-1:0]            hit_w;
    logic [N_OUT-1:0]            en_w;
    logic [N_OUT-1:0]            lat_w;
    logic [N_OUT-1:0]            live_w;

    pcmp_preset_bank #(.ACC_W(ACC_W), .N_PRE(N_PRE), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (pst_we_i),
        .sel_i  (pst_sel_i),
        .data_i (pst_data_i),
        .pre_o  (pre_w)
    );

    pcmp_cmp_array #(.ACC_W(ACC_W), .N_PRE(N_PRE)) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_i   (acc_i),
        .pre_i   (pre_w),
        .sense_i (sense_i),
        .hit_o   (hit_w)
    );

    pcmp_out_ctrl #(.N_OUT(N_OUT)) u_octl (
        .clk             (clk),
        .rst_n           (rst_n),
        .hit_i           (hit_w[N_OUT-1:0]),
        .cmd_we_i        (dcmd_we_i),
        .cmd_en_i        (dcmd_en_i),
        .cmd_lat_i       (dcmd_lat_i),
        .home_act_i      (home_act_i),
        .host_rst_i      (host_rst_i),
        .force_off_sel_i (force_off_sel_i),
        .en_o            (en_w),
        .lat_o           (lat_w),
        .live_o          (live_w),
        .out_o           (out_o)
    );

    assign cmp_o = hit_w;
endmodule

// File: rtl/pcmp_checker.sv
module pcmp_checker #(
    parameter int N_OUT = pcmp_pkg::PCMP_N_OUT,
    parameter int N_PRE = pcmp_pkg::PCMP_N_PRE
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_PRE-1:0] cmp_o,
    input logic [N_OUT-1:0] out_o,
    input logic [N_OUT-1:0] en_w,
    input logic [N_OUT-1:0] lat_w,
    input logic [N_OUT-1:0] live_w,
    input logic             home_act_i,
    input logic             host_rst_i,
    input logic             force_off_sel_i
);
    // R7: masking during host reset
    a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off_sel_i && host_rst_i) |-> (out_o == '0));

    // R4: a latched output that is on stays on
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_w & lat_w) != '0) |=> ((live_w & $past(live_w & lat_w)) == $past(live_w & lat_w)));

    // R4: unlatched output with failed compare goes off
    a_r4_drop_off: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((live_w & $past(~lat_w & ~cmp_o[N_OUT-1:0])) == '0));

    // R3: a disabled output that is off cannot turn on
    a_r3_no_rise_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((live_w & ~$past(live_w) & ~$past(en_w)) == '0));

    // R6: home search clears enables and latches
    a_r6_home_clear: assert property (@(posedge clk) disable iff (!rst_n)
        home_act_i |=> (en_w == '0 && lat_w == '0));
endmodule

bind preset_cmp_ctrl pcmp_checker #(.N_OUT(N_OUT), .N_PRE(N_PRE)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmp_o           (cmp_o),
    .out_o           (out_o),
    .en_w            (en_w),
    .lat_w           (lat_w),
    .live_w          (live_w),
    .home_act_i      (home_act_i),
    .host_rst_i      (host_rst_i),
    .force_off_sel_i (force_off_sel_i)
);

// File: tb/sim_preset_cmp_ctrl.sv
`timescale 1ns/1ps
module sim_preset_cmp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] acc_i = '0;
    logic        pst_we_i = 1'b0;
    logic [3:0]  pst_sel_i = '0;
    logic [23:0] pst_data_i = '0;
    logic [11:0] sense_i = '0;
    logic        dcmd_we_i = 1'b0;
    logic [3:0]  dcmd_en_i = '0;
    logic [3:0]  dcmd_lat_i = '0;
    logic        home_act_i = 1'b0;
    logic        host_rst_i = 1'b0;
    logic        force_off_sel_i = 1'b0;
    logic [3:0]  out_o;
    logic [11:0] cmp_o;

    int checks = 0;
    int errors = 0;
    logic signed [23:0] mp [12];

    always #4 clk = ~clk;

    preset_cmp_ctrl u0 (.*);

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] model_cmp(input logic signed [23:0] a, input logic [11:0] s);
        logic [11:0] r;
        for (int k = 0; k < 12; k++)
            r[k] = s[k] ? (a < mp[k]) : (a >= mp[k]);
        return r;
    endfunction

    task automatic wr_pre(input int idx, input logic signed [23:0] v);
        pst_we_i = 1'b1; pst_sel_i = 4'(idx); pst_data_i = v;
        step();
        pst_we_i = 1'b0;
        if (idx < 12) mp[idx] = v;
    endtask

    task automatic dcmd(input logic [3:0] en, input logic [3:0] lat);
        dcmd_we_i = 1'b1; dcmd_en_i = en; dcmd_lat_i = lat;
        step();
        dcmd_we_i = 1'b0;
    endtask

    task automatic t_reset;
        for (int k = 0; k < 12; k++) mp[k] = '0;
        rst_n = 1'b0;
        step(3);
        chk(out_o == 4'h0, "R8 out in reset", 32'(out_o), 0);
        rst_n = 1'b1;
        step();
        chk(cmp_o == 12'hFFF, "R8 presets zero", 32'(cmp_o), 32'hFFF);
        chk(out_o == 4'h0, "R8 out after reset", 32'(out_o), 0);
    endtask

    task automatic t_compare;
        logic signed [23:0] accs [6];
        accs = '{-24'sd8388608, -24'sd501, -24'sd500, 24'sd0, 24'sd999, 24'sd8388607};
        wr_pre(0, -24'sd500);  wr_pre(1, 24'sd1000); wr_pre(4, 24'sd0);
        wr_pre(7, -24'sd8388608); wr_pre(11, 24'sd8388607); wr_pre(9, 24'sd999);
        // R1: out-of-range index ignored
        wr_pre(12, 24'sd5); wr_pre(15, -24'sd5);
        for (int s = 0; s < 2; s++) begin
            sense_i = (s == 0) ? 12'h000 : 12'hA5C;
            for (int i = 0; i < 6; i++) begin
                acc_i = accs[i];
                step();
                chk(cmp_o == model_cmp(accs[i], sense_i), "R2 compare (R1 loaded)",
                    32'(cmp_o), 32'(model_cmp(accs[i], sense_i)));
            end
        end
        sense_i = '0;
    endtask

    task automatic t_enable;
        wr_pre(0, 24'sd100);
        acc_i = 24'sd50;
        dcmd(4'b0001, 4'b0000);
        step(2);
        chk(out_o[0] == 1'b0, "R3 below preset off", 32'(out_o), 0);
        acc_i = 24'sd150;
        step(2);
        chk(out_o[0] == 1'b1, "R3 enabled on", 32'(out_o[0]), 1);
        chk(out_o[1] == 1'b0, "R5 output1 not enabled", 32'(out_o[1]), 0);
        acc_i = 24'sd50;
        step(2);
        chk(out_o[0] == 1'b0, "R4 drops when compare false", 32'(out_o[0]), 0);
    endtask

    task automatic t_latch;
        acc_i = 24'sd150;
        dcmd(4'b0001, 4'b0000);
        step(2);
        dcmd(4'b0000, 4'b0001);
        acc_i = 24'sd50;
        step(3);
        chk(out_o[0] == 1'b1, "R4 latched holds", 32'(out_o[0]), 1);
        dcmd(4'b0000, 4'b0000);
        step(2);
        chk(out_o[0] == 1'b0, "R4 unlatch releases", 32'(out_o[0]), 0);
        dcmd(4'b0000, 4'b0001);
        acc_i = 24'sd150;
        step(3);
        chk(out_o[0] == 1'b0, "R4 latch does not turn on", 32'(out_o[0]), 0);
    endtask

    task automatic t_home;
        acc_i = 24'sd150;
        dcmd(4'b0001, 4'b0001);
        step(2);
        chk(out_o[0] == 1'b1, "R6 pre-home on", 32'(out_o[0]), 1);
        home_act_i = 1'b1;
        step();
        dcmd(4'b0001, 4'b0000);
        step(2);
        chk(out_o[0] == 1'b0, "R6 home clears", 32'(out_o[0]), 0);
        home_act_i = 1'b0;
        step(3);
        chk(out_o[0] == 1'b0, "R6 stays disabled", 32'(out_o[0]), 0);
        dcmd(4'b0001, 4'b0000);
        step(2);
        chk(out_o[0] == 1'b1, "R6 re-enabled", 32'(out_o[0]), 1);
    endtask

    task automatic t_force;
        force_off_sel_i = 1'b0; host_rst_i = 1'b1;
        #1;
        chk(out_o[0] == 1'b1, "R7 no effect when unselected", 32'(out_o[0]), 1);
        force_off_sel_i = 1'b1;
        #1;
        chk(out_o == 4'h0, "R7 forced off", 32'(out_o), 0);
        step(3);
        chk(out_o == 4'h0, "R7 held off", 32'(out_o), 0);
        host_rst_i = 1'b0;
        #1;
        chk(out_o[0] == 1'b1, "R7 restored", 32'(out_o[0]), 1);
        force_off_sel_i = 1'b0;
    endtask

    task automatic t_internal;
        dcmd(4'b1111, 4'b0000);
        wr_pre(1, 24'sd1000); wr_pre(2, 24'sd1000); wr_pre(3, 24'sd1000);
        acc_i = 24'sd150;
        for (int k = 4; k < 12; k++) wr_pre(k, -24'sd10);
        step(2);
        chk(cmp_o[11:4] == 8'hFF, "R9 internal hits", 32'(cmp_o), 32'hFF0);
        chk(out_o == 4'b0001, "R9 internal no output", 32'(out_o), 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_compare();
                t_enable();
                t_latch();
                t_home();
                t_force();
                t_internal();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule